// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

A combinational binary adder that forms every carry from generate and propagate terms instead of letting a carry travel bit by bit. Operand bits are grouped into nibbles; each nibble derives its internal carries as flat sum-of-products terms of its own generate and propagate bits and the nibble carry-in. Each nibble also reports a nibble-level propagate and generate. A second lookahead stage joins up to four nibbles into a section of at most 16 bits, using the same flat form at nibble level.

Wider adders are built as a chain of sections. The carry-out of one section is the carry-in of the next. The width is a parameter that must be a multiple of 4. When the width is not a multiple of 16, the last section holds fewer nibbles. The per-nibble propagate and generate outputs let an enclosing datapath build a further level of lookahead.

Top module: `cla_adder`

## Requirements
- R1: For every input, `{c_o, s_o}` equals `x_i + y_i + c_i` taken as an unsigned WIDTH+1-bit sum.
- R2: WIDTH may be any multiple of 4. Widths that are not a multiple of 16 leave a partial final section and still meet R1.
- R3: `grp_p_o[k]` is 1 exactly when nibble k of the operands, bits 4k+3 down to 4k, adds to 15 with no carry-in. Such a nibble passes its carry-in straight through.
- R4: `grp_g_o[k]` is 1 exactly when nibble k of the operands adds to 16 or more with no carry-in. Such a nibble produces a carry-out whatever its carry-in.
- R5: `grp_p_o[k]` and `grp_g_o[k]` are never 1 together.
- R6: With `y_i == ~x_i` and `c_i = 1`, the carry crosses every nibble and every section: `s_o` is all zeros and `c_o` is 1.
- R7: With `y_i == ~x_i` and `c_i = 0`, `s_o` is all ones and `c_o` is 0.
- R8: A carry leaving bit 15 of a lower section enters the next section. For example, 0x0000FFFF + 1 gives 0x00010000 at 32 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_i | input | WIDTH | First operand |
| y_i | input | WIDTH | Second operand |
| c_i | input | 1 | Carry into bit 0 |
| s_o | output | WIDTH | Sum |
| c_o | output | 1 | Carry out of the top bit |
| grp_p_o | output | WIDTH/4 | Per-nibble propagate |
| grp_g_o | output | WIDTH/4 | Per-nibble generate |

## Verification
The bench builds four copies of the adder, at widths 4, 16, 24 and 32, and drives every copy with the same stimulus. At 4 bits, all 512 combinations of operands and carry-in are applied, so every nibble lookahead term is covered exhaustively. The 16-bit copy exercises a full second-level stage. The 24-bit copy brings a partial final section of two nibbles within reach. The 32-bit copy exercises the carry hand-off between sections, with random vectors and full-length propagate chains.

// File: rtl/cla_pkg.sv
package cla_pkg;

  localparam int unsigned GRP_BITS = 4;
  localparam int unsigned SEC_GRPS = 4;

  typedef logic [GRP_BITS-1:0] nib_t;

  // flat two-level carries c1..c4 from p/g and carry-in
  function automatic logic [4:1] lookahead4(input nib_t p, input nib_t g, input logic c0);
    logic [4:1] c;
    c[1] = g[0] | (p[0] & c0);
    c[2] = g[1] | (p[1] & g[0]) | (p[1] & p[0] & c0);
    c[3] = g[2] | (p[2] & g[1]) | (p[2] & p[1] & g[0]) | (p[2] & p[1] & p[0] & c0);
    c[4] = g[3] | (p[3] & g[2]) | (p[3] & p[2] & g[1]) | (p[3] & p[2] & p[1] & g[0])
         | (p[3] & p[2] & p[1] & p[0] & c0);
    return c;
  endfunction

  function automatic logic group_gen(input nib_t p, input nib_t g);
    return g[3] | (p[3] & g[2]) | (p[3] & p[2] & g[1]) | (p[3] & p[2] & p[1] & g[0]);
  endfunction

  function automatic logic group_prop(input nib_t p);
    return &p;
  endfunction

endpackage

// File: rtl/cla_grp4.sv
module cla_grp4
  import cla_pkg::*;
(
  input  nib_t x_i,
  input  nib_t y_i,
  input  logic c_i,
  output nib_t s_o,
  output logic gp_o,
  output logic gg_o
);

  nib_t       p, g, cin;
  logic [4:1] c;

  assign p    = x_i ^ y_i;
  assign g    = x_i & y_i;
  assign c    = lookahead4(p, g, c_i);
  assign cin  = {c[3:1], c_i};
  assign s_o  = p ^ cin;
  assign gp_o = group_prop(p);
  assign gg_o = group_gen(p, g);

endmodule

// File: rtl/cla_lcu.sv
module cla_lcu
  import cla_pkg::*;
#(
  parameter int unsigned NG = 4
) (
  input  logic [NG-1:0] gp_i,
  input  logic [NG-1:0] gg_i,
  input  logic          c_i,
  output logic [NG:0]   c_o
);

  nib_t       pp, gg;
  logic [4:1] c;

  // unused nibble slots neither propagate nor generate
  always_comb begin
    pp = '0;
    gg = '0;
    pp[NG-1:0] = gp_i;
    gg[NG-1:0] = gg_i;
  end

  assign c = lookahead4(pp, gg, c_i);

  always_comb begin
    c_o[0] = c_i;
    for (int k = 1; k <= NG; k++) c_o[k] = c[k];
  end

endmodule

// File: rtl/cla_sec.sv
module cla_sec
  import cla_pkg::*;
#(
  parameter int unsigned NG = 4,
  localparam int unsigned W = NG * GRP_BITS
) (
  input  logic [W-1:0]  x_i,
  input  logic [W-1:0]  y_i,
  input  logic          c_i,
  output logic [W-1:0]  s_o,
  output logic          c_o,
  output logic [NG-1:0] gp_o,
  output logic [NG-1:0] gg_o
);

  logic [NG:0] gc;

  cla_lcu #(.NG(NG)) u_lcu (
    .gp_i (gp_o),
    .gg_i (gg_o),
    .c_i  (c_i),
    .c_o  (gc)
  );

  for (genvar k = 0; k < NG; k++) begin : g_grp
    cla_grp4 u_grp (
      .x_i  (x_i[k*GRP_BITS +: GRP_BITS]),
      .y_i  (y_i[k*GRP_BITS +: GRP_BITS]),
      .c_i  (gc[k]),
      .s_o  (s_o[k*GRP_BITS +: GRP_BITS]),
      .gp_o (gp_o[k]),
      .gg_o (gg_o[k])
    );
  end

  assign c_o = gc[NG];

endmodule

// File: rtl/cla_adder.sv
module cla_adder
  import cla_pkg::*;
#(
  parameter int unsigned WIDTH = 32,
  localparam int unsigned NGRP = WIDTH / GRP_BITS,
  localparam int unsigned NSEC = (NGRP + SEC_GRPS - 1) / SEC_GRPS
) (
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  input  logic             c_i,
  output logic [WIDTH-1:0] s_o,
  output logic             c_o,
  output logic [NGRP-1:0]  grp_p_o,
  output logic [NGRP-1:0]  grp_g_o
);

  logic [NSEC:0] sec_c;

  assign sec_c[0] = c_i;

  for (genvar i = 0; i < NSEC; i++) begin : g_sec
    localparam int unsigned REM = NGRP - i * SEC_GRPS;
    localparam int unsigned NG  = (REM >= SEC_GRPS) ? SEC_GRPS : REM;
    localparam int unsigned LO  = i * SEC_GRPS * GRP_BITS;
    localparam int unsigned GLO = i * SEC_GRPS;

    cla_sec #(.NG(NG)) u_sec (
      .x_i  (x_i[LO +: NG*GRP_BITS]),
      .y_i  (y_i[LO +: NG*GRP_BITS]),
      .c_i  (sec_c[i]),
      .s_o  (s_o[LO +: NG*GRP_BITS]),
      .c_o  (sec_c[i+1]),
      .gp_o (grp_p_o[GLO +: NG]),
      .gg_o (grp_g_o[GLO +: NG])
    );
  end

  assign c_o = sec_c[NSEC];

endmodule

// File: rtl/cla_adder_chk.sv
module cla_adder_chk #(
  parameter int unsigned WIDTH = 32,
  localparam int unsigned NGRP = WIDTH / 4
) (
  input logic [WIDTH-1:0] x_i,
  input logic [WIDTH-1:0] y_i,
  input logic             c_i,
  input logic [WIDTH-1:0] s_o,
  input logic             c_o,
  input logic [NGRP-1:0]  grp_p_o,
  input logic [NGRP-1:0]  grp_g_o
);

  logic [WIDTH:0] ref_sum;
  assign ref_sum = {1'b0, x_i} + {1'b0, y_i} + {{WIDTH{1'b0}}, c_i};

  always_comb begin
    assert_sum_R1: assert ({c_o, s_o} == ref_sum)
      else $error("sum mismatch");
  end

  always_comb begin
    for (int k = 0; k < NGRP; k++) begin
      assert_excl_R5: assert (!(grp_p_o[k] && grp_g_o[k]))
        else $error("nibble %0d both propagate and generate", k);
      assert_grp_p_R3: assert (!grp_p_o[k] ||
          (({1'b0, x_i[k*4 +: 4]} + {1'b0, y_i[k*4 +: 4]}) == 5'd15))
        else $error("nibble %0d propagate wrong", k);
      assert_grp_g_R4: assert (!grp_g_o[k] ||
          (({1'b0, x_i[k*4 +: 4]} + {1'b0, y_i[k*4 +: 4]}) >= 5'd16))
        else $error("nibble %0d generate wrong", k);
    end
  end

endmodule

bind cla_adder cla_adder_chk #(.WIDTH(WIDTH)) u_chk (
  .x_i     (x_i),
  .y_i     (y_i),
  .c_i     (c_i),
  .s_o     (s_o),
  .c_o     (c_o),
  .grp_p_o (grp_p_o),
  .grp_g_o (grp_g_o)
);

// File: tb/sim_cla_adder.sv
module sim_cla_adder;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [31:0] xa, ya;
  logic        ca;

  logic [3:0]  s4;  logic c4;  logic [0:0] p4, g4;
  logic [15:0] s16; logic c16; logic [3:0] p16, g16;
  logic [23:0] s24; logic c24; logic [5:0] p24, g24;
  logic [31:0] s32; logic c32; logic [7:0] p32, g32;

  cla_adder #(.WIDTH(32)) u0 (
    .x_i(xa), .y_i(ya), .c_i(ca), .s_o(s32), .c_o(c32), .grp_p_o(p32), .grp_g_o(g32));
  cla_adder #(.WIDTH(4)) u1 (
    .x_i(xa[3:0]), .y_i(ya[3:0]), .c_i(ca), .s_o(s4), .c_o(c4), .grp_p_o(p4), .grp_g_o(g4));
  cla_adder #(.WIDTH(16)) u2 (
    .x_i(xa[15:0]), .y_i(ya[15:0]), .c_i(ca), .s_o(s16), .c_o(c16), .grp_p_o(p16), .grp_g_o(g16));
  cla_adder #(.WIDTH(24)) u3 (
    .x_i(xa[23:0]), .y_i(ya[23:0]), .c_i(ca), .s_o(s24), .c_o(c24), .grp_p_o(p24), .grp_g_o(g24));

  task automatic chk_one(input int w, input logic [31:0] s, input logic co,
                         input logic [7:0] gp, input logic [7:0] gg, input string tag);
    logic [31:0] mask;
    logic [32:0] full;
    logic [4:0]  nib;
    string       rt;
    mask = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 1);
    full = {1'b0, xa & mask} + {1'b0, ya & mask} + {32'd0, ca};
    rt = (w == 24) ? {tag, "/R2"} : tag;
    checks++;
    if ({co, s & mask} != {full[w], full[31:0] & mask}) begin
      errors++;
      $display("FAIL %s w=%0d x=%h y=%h c=%0d: got c=%0d s=%h exp c=%0d s=%h",
               rt, w, xa & mask, ya & mask, ca, co, s & mask, full[w], full[31:0] & mask);
    end
    for (int k = 0; k < w / 4; k++) begin
      nib = {1'b0, xa[k*4 +: 4]} + {1'b0, ya[k*4 +: 4]};
      checks++;
      if (gp[k] != (nib == 5'd15)) begin
        errors++;
        $display("FAIL R3 w=%0d nibble %0d: got %0d exp %0d", w, k, gp[k], nib == 5'd15);
      end
      checks++;
      if (gg[k] != (nib >= 5'd16)) begin
        errors++;
        $display("FAIL R4 w=%0d nibble %0d: got %0d exp %0d", w, k, gg[k], nib >= 5'd16);
      end
      checks++;
      if (gp[k] && gg[k]) begin
        errors++;
        $display("FAIL R5 w=%0d nibble %0d: got p=1 g=1 exp not both", w, k);
      end
    end
  endtask

  task automatic apply(input logic [31:0] x, input logic [31:0] y, input logic c, input string tag);
    @(negedge clk);
    xa = x; ya = y; ca = c;
    #2;
    chk_one(32, s32, c32, p32, g32, tag);
    chk_one(4, {28'd0, s4}, c4, {7'd0, p4}, {7'd0, g4}, tag);
    chk_one(16, {16'd0, s16}, c16, {4'd0, p16}, {4'd0, g16}, tag);
    chk_one(24, {8'd0, s24}, c24, {2'd0, p24}, {2'd0, g24}, tag);
  endtask

  task automatic expect32(input logic [31:0] s_exp, input logic c_exp, input string tag);
    checks++;
    if ({c32, s32} != {c_exp, s_exp}) begin
      errors++;
      $display("FAIL %s: got c=%0d s=%h exp c=%0d s=%h", tag, c32, s32, c_exp, s_exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    xa = '0; ya = '0; ca = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // idle state: zero operands give zero sum and no group flags
    apply(32'd0, 32'd0, 1'b0, "R1");
    expect32(32'd0, 1'b0, "R1 idle");

    // exhaustive 4-bit sweep
    for (int c = 0; c < 2; c++)
      for (int x = 0; x < 16; x++)
        for (int y = 0; y < 16; y++)
          apply(32'(x), 32'(y), c[0], "R1");

    // full-length propagate chains
    apply(32'h1234_5678, ~32'h1234_5678, 1'b1, "R6");
    expect32(32'd0, 1'b1, "R6");
    apply(32'hA5A5_0F0F, ~32'hA5A5_0F0F, 1'b0, "R7");
    expect32(32'hFFFF_FFFF, 1'b0, "R7");
    apply(32'hFFFF_FFFF, 32'd0, 1'b1, "R6");
    expect32(32'd0, 1'b1, "R6");

    // section hand-off
    apply(32'h0000_FFFF, 32'd1, 1'b0, "R8");
    expect32(32'h0001_0000, 1'b0, "R8");
    apply(32'h7FFF_FFFF, 32'd0, 1'b1, "R8");
    expect32(32'h8000_0000, 1'b0, "R8");
    apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, "R1");
    expect32(32'hFFFF_FFFF, 1'b1, "R1 max");

    // random vectors
    for (int n = 0; n < 2000; n++)
      apply($urandom, $urandom, 1'($urandom), "R1");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule